// File: doc/BRIEF.md
# Fixed-Point Rounding Right Shifter

This block narrows one fixed-point element by discarding its low `d` bits and rounding what remains. The operand is shifted right, either arithmetically (sign fill) or logically (zero fill), and a one-bit increment is then added to the shifted value.

A two-bit mode input picks how the increment is formed. The increment depends on three bits. The guard bit is the highest discarded bit. The sticky bit is the OR of all discarded bits below the guard. The LSB is the lowest bit that is kept. The four modes are nearest-up, nearest-even, truncate and round-to-odd ("jam").

One instance handles one element. By default the result is captured in an output register under a load enable. With `REG_OUT` set to 0 the result passes straight through as a combinational path.

Top module: `rshr_round`

## Requirements
- R1: With `REG_OUT`=1, `res` takes `((v >> dc) + r) mod 2^W` on the rising clock edge at which `ld` is high, and not before. `dc` is the effective shift count; `r` is the mode's increment.
- R2: Mode 2'b00 (nearest-up): `r` equals the guard bit `v[dc-1]`.
- R3: Mode 2'b01 (nearest-even): `r` equals guard AND (sticky OR LSB). An exact half therefore rounds to an even result.
- R4: Mode 2'b10 (truncate): `r` is 0 for every operand and count.
- R5: Mode 2'b11 (round-to-odd): `r` equals NOT LSB AND (guard OR sticky). Any nonzero discarded bit therefore leaves the result LSB at 1.
- R6: A shift count of 0 discards nothing, so `r` is 0 in every mode and the result equals `v`.
- R7: A shift count of 1 has an empty sticky field. The guard is `v[0]` and sticky counts as 0.
- R8: A count of W or more behaves exactly as a count of W. The shifted value is all fill bits (sign with `sgn`=1, zero with `sgn`=0), the guard is `v[W-1]`, the sticky bit is the OR of `v[W-2:0]`, and the LSB is the fill bit.
- R9: `sgn`=1 treats `v` as two's complement and shifts arithmetically. `sgn`=0 treats it as unsigned and shifts logically.
- R10: While `rst_n` is low, and after its release until the first load, `res` is 0.
- R11: While `ld` is low, `res` holds its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld | input | 1 | Load enable for the output register |
| v | input | W | Pre-rounding operand |
| d | input | $clog2(W)+1 | Number of low bits to discard |
| sgn | input | 1 | 1: arithmetic shift, 0: logical shift |
| mode | input | 2 | Rounding mode: 00 near-up, 01 near-even, 10 truncate, 11 odd |
| res | output | W | Rounded, shifted result |

## Verification
With the output register in place, every rounded result is due exactly one rising edge after the inputs are presented with `ld` high. The bench drives inputs on the falling edge and samples `res` 1 ns after the following rising edge, so each sample sees exactly one register update. A separate check samples just before that edge to confirm that the old value is still present. The hold check keeps `ld` low across several edges while the other inputs change, and compares `res` after each of those edges.

// File: rtl/rshr_pkg.sv
package rshr_pkg;

  typedef enum logic [1:0] {
    RM_NEAR_UP   = 2'b00,
    RM_NEAR_EVEN = 2'b01,
    RM_DOWN      = 2'b10,
    RM_ODD       = 2'b11
  } rmode_e;

  typedef struct packed {
    logic lsb;
    logic guard;
    logic sticky;
  } rbits_t;

endpackage

// File: rtl/rshr_shift.sv
// Fill-extended right shift by an already clamped count (0..W).
module rshr_shift #(
  parameter int W  = 16,
  parameter int SW = 5
) (
  input  logic [W-1:0]  v,
  input  logic [SW-1:0] dc,
  input  logic          sgn,
  output logic [W-1:0]  q
);

  logic           fill;
  logic [2*W-1:0] ext;
  logic [2*W-1:0] sh;

  always_comb begin
    fill = sgn & v[W-1];
    ext  = {{W{fill}}, v};
    sh   = ext >> dc;
    q    = sh[W-1:0];
  end

endmodule

// File: rtl/rshr_tail.sv
// Extracts the guard and sticky bits from the discarded part of v.
module rshr_tail #(
  parameter int W  = 16,
  parameter int SW = 5
) (
  input  logic [W-1:0]  v,
  input  logic [SW-1:0] dc,
  output logic          guard,
  output logic          sticky
);

  logic [W-1:0] gsel;   // one-hot at dc-1
  logic [W-1:0] below;  // ones at positions 0..dc-2

  for (genvar i = 0; i < W; i++) begin : g_mask
    localparam logic [SW-1:0] POS_G = SW'(i + 1);
    localparam logic [SW-1:0] POS_S = SW'(i + 2);
    assign gsel[i]  = (dc == POS_G);
    assign below[i] = (dc >= POS_S);
  end

  always_comb begin
    guard  = |(v & gsel);
    sticky = |(v & below);
  end

endmodule

// File: rtl/rshr_incr.sv
// Selects the one-bit rounding increment from the mode.
module rshr_incr
  import rshr_pkg::*;
(
  input  logic [1:0] mode,
  input  rbits_t     bits,
  output logic       r
);

  rmode_e m;

  always_comb begin
    m = rmode_e'(mode);
    unique case (m)
      RM_NEAR_UP:   r = bits.guard;
      RM_NEAR_EVEN: r = bits.guard & (bits.sticky | bits.lsb);
      RM_DOWN:      r = 1'b0;
      RM_ODD:       r = ~bits.lsb & (bits.guard | bits.sticky);
      default:      r = 1'b0;
    endcase
  end

endmodule

// File: rtl/rshr_round.sv
module rshr_round
  import rshr_pkg::*;
#(
  parameter  int W       = 16,
  parameter  int REG_OUT = 1,
  localparam int SW      = $clog2(W) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [W-1:0]  v,
  input  logic [SW-1:0] d,
  input  logic          sgn,
  input  logic [1:0]    mode,
  output logic [W-1:0]  res
);

  localparam logic [SW-1:0] W_S = SW'(W);

  logic [SW-1:0] dc;
  logic [W-1:0]  q;
  logic          guard;
  logic          sticky;
  logic          r;
  rbits_t        bits;
  logic [W-1:0]  res_d;

  // count clamp: anything at or beyond W behaves as W
  always_comb dc = (d >= W_S) ? W_S : d;

  rshr_shift #(.W(W), .SW(SW)) u_shift (
    .v   (v),
    .dc  (dc),
    .sgn (sgn),
    .q   (q)
  );

  rshr_tail #(.W(W), .SW(SW)) u_tail (
    .v      (v),
    .dc     (dc),
    .guard  (guard),
    .sticky (sticky)
  );

  always_comb begin
    bits.lsb    = q[0];
    bits.guard  = guard;
    bits.sticky = sticky;
  end

  rshr_incr u_incr (
    .mode (mode),
    .bits (bits),
    .r    (r)
  );

  always_comb res_d = q + {{(W-1){1'b0}}, r};

  if (REG_OUT != 0) begin : g_reg
    logic [W-1:0] res_q;
    logic [W-1:0] res_n;

    always_comb res_n = ld ? res_d : res_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q <= '0;
      else        res_q <= res_n;
    end

    assign res = res_q;
  end else begin : g_comb
    assign res = res_d;
  end

endmodule

// File: rtl/rshr_round_chk.sv
module rshr_round_chk
  import rshr_pkg::*;
#(
  parameter  int W       = 16,
  parameter  int REG_OUT = 1,
  localparam int SW      = $clog2(W) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld,
  input logic [W-1:0]  v,
  input logic [SW-1:0] d,
  input logic          sgn,
  input logic [1:0]    mode,
  input logic [W-1:0]  res
);

  localparam logic [SW-1:0] W_S = SW'(W);

  if (REG_OUT != 0) begin : g_props
    // R10
    rst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> res == '0);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(res));

    // R6
    no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && d == '0) |=> res == $past(v));

    // R8
    wide_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !sgn && d >= W_S && mode == RM_DOWN) |=> res == '0);

    // R5
    jam_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && mode == RM_ODD && d != '0 && v[0]) |=> res[0]);

    // R3
    tie_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && mode == RM_NEAR_EVEN && d == SW'(1) && v[0]) |=> !res[0]);
  end

endmodule

bind rshr_round rshr_round_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ld    (ld),
  .v     (v),
  .d     (d),
  .sgn   (sgn),
  .mode  (mode),
  .res   (res)
);

// File: tb/sim_rshr_round.sv
`timescale 1ns/1ps
module sim_rshr_round;

  localparam int W  = 8;
  localparam int SW = $clog2(W) + 1;

  logic          clk;
  logic          rst_n;
  logic          ld;
  logic [W-1:0]  v;
  logic [SW-1:0] d;
  logic          sgn;
  logic [1:0]    mode;
  logic [W-1:0]  res;

  int checks;
  int errors;

  rshr_round #(.W(W), .REG_OUT(1)) u0 (
    .clk(clk), .rst_n(rst_n), .ld(ld), .v(v), .d(d),
    .sgn(sgn), .mode(mode), .res(res)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // arithmetic reference: floor division and remainder
  function automatic logic [W-1:0] model(int val, int dd, int md, bit sg);
    int x, n, q, rem, half;
    bit g, s, l, r;
    x = (sg && val >= (1 << (W-1))) ? val - (1 << W) : val;
    n = (dd > W) ? W : dd;
    q = x >>> n;
    rem = x - q * (1 << n);
    if (n == 0) begin
      g = 1'b0; s = 1'b0;
    end else begin
      half = 1 << (n - 1);
      g = (rem >= half);
      s = ((rem % half) != 0);
    end
    l = q[0];
    case (md)
      0: r = g;
      1: r = g & (s | l);
      2: r = 1'b0;
      default: r = ~l & (g | s);
    endcase
    return W'(q + int'(r));
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    finish_sim();
  end

  initial begin
    logic [W-1:0] held;
    string tag;
    checks = 0; errors = 0;
    rst_n = 1'b0; ld = 1'b0; v = '0; d = '0; sgn = 1'b0; mode = 2'b00;
    repeat (3) @(negedge clk);
    check("R10 in reset", res, '0);
    rst_n = 1'b1;
    v = 8'hA5; d = 4'd2; mode = 2'b00;
    @(posedge clk); #1;
    check("R10 after release", res, '0);

    // R1: result appears only at the loading edge
    @(negedge clk);
    ld = 1'b1; v = 8'h37; d = 4'd3; sgn = 1'b0; mode = 2'b00;
    #1;
    check("R1 before edge", res, '0);
    @(posedge clk); #1;
    check("R1 at edge", res, model(8'h37, 3, 0, 1'b0));

    // R11: hold while ld low
    @(negedge clk);
    held = res;
    ld = 1'b0;
    for (int k = 0; k < 4; k++) begin
      v = W'(k * 53 + 7); d = SW'(k); mode = 2'(k); sgn = k[0];
      @(posedge clk); #1;
      check("R11 hold", res, held);
      @(negedge clk);
    end

    // exhaustive sweep
    ld = 1'b1;
    for (int sg = 0; sg < 2; sg++)
      for (int md = 0; md < 4; md++)
        for (int dd = 0; dd < (1 << SW); dd++)
          for (int vv = 0; vv < (1 << W); vv++) begin
            @(negedge clk);
            v = W'(vv); d = SW'(dd); sgn = sg[0]; mode = 2'(md);
            @(posedge clk); #1;
            if (dd == 0)       tag = "R6 zero count";
            else if (dd == 1)  tag = "R7 unit count";
            else if (dd >= W)  tag = "R8 wide count";
            else if (md == 0)  tag = "R2 near-up";
            else if (md == 1)  tag = "R3 near-even";
            else if (md == 2)  tag = "R4 truncate";
            else               tag = "R5 odd";
            if (sg != 0) tag = {tag, " R9 signed"};
            check(tag, res, model(vv, dd, md, sg[0]));
          end

    finish_sim();
  end

endmodule